// File: doc/BRIEF.md
# Buffered Dual-Channel PWM Timer

This block holds a free-running up-counter and two compare channels that are linked into one pulse-width-modulated output. The counter steps from zero up to a programmable period value, wraps to zero, and marks that wrap with a one-cycle event. The output level comes from two actions. A compare match forces the output to a programmed level. Each wrap can toggle the output. The pulse width is therefore the span between the wrap and the match.

Software programs the block through a small write-only register port. It sets the period, the two compare values and the channel configuration, and it clears the halt bit last. In direct mode, channel 0's compare register drives the output at once. In buffered mode the two compare registers take turns. A value written to the idle register waits until the next wrap, and only then does that register take control. A duty change therefore never shortens or doubles a period. Two cases have dedicated handling. With the toggle disabled the output settles to a constant 0 % duty. With the max-duty bit and the toggle both set the output holds a constant 100 % duty.

Top module: `pwm_pair_timer`

Register addresses: 0 control (bit 0 = halt), 1 period, 2 compare 0, 3 compare 1, 4 channel 0 configuration, 5 channel 1 configuration.

Layout of the configuration register at address 4:

| Bits | Field |
|------|-------|
| [1:0] | mode |
| [3:2] | level select |
| 4 | toggle on wrap |
| 5 | max duty |
| 7 | write 1 to clear the flag (not stored) |

At address 5 only bit 7 has an effect: writing 1 clears flag 1.

Every output change caused by an event in cycle N is visible in cycle N+1.

## Requirements
- R1: After reset, halt = 1, period = all ones, both compare registers = 0, configuration = 0, count = 0, output = 0, both flags = 0.
- R2: While running, the count rises by one per cycle. In the cycle where the count equals the period, wrap_o is high, and the next count is 0.
- R3: While halt (address 0 bit 0) is 1, the count holds. No compare action and no wrap action occur, so the output holds. Clearing halt resumes counting from the held value.
- R4: Mode bits [1:0] are decoded with bit 1 taking priority. If bit 1 is 1 (values 10 and 11), the mode is buffered. The value 01 selects direct mode. The value 00 turns the output actions off, and the output holds its level.
- R5: Level select bits [3:2] set the compare action. The value 10 forces the output to 0 on a match, and 11 forces it to 1. Any value with bit 3 = 0 gives no compare action. The pulse level is the inverse of bit 2.
- R6: With the toggle bit (bit 4) set, the output inverts after each wrap. With it clear, no wrap toggle occurs, and the output settles at the compare level, giving 0 % duty.
- R7: With max duty (bit 5) and the toggle bit both set, the output is held at the pulse level in every running cycle, giving 100 % duty.
- R8: In direct mode, a match means count = compare 0. A newly written compare 0 takes effect in the very next cycle.
- R9: In buffered mode, channel 0 controls first. A write to the inactive compare register marks it pending. At the next wrap control passes to that register. Otherwise the active register's value is reloaded at each wrap, and the active value never changes between wraps.
- R10: Each channel's flag is set one cycle after the count equals that channel's compare register while running. Writing 1 to bit 7 of that channel's configuration address clears the flag, and a set in the same cycle wins.
- R11: When a match with a compare action falls in the same cycle as a wrap, the compare action wins over the toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output |
| count_o | output | CNT_W | Current counter value |
| wrap_o | output | 1 | High in the cycle the counter wraps |
| flag0_o | output | 1 | Channel 0 compare flag |
| flag1_o | output | 1 | Channel 1 compare flag |

## Verification
A wrong count or a wrong wrap decision is visible on count_o and wrap_o in the same cycle. Any fault in the output decision reaches pwm_o one cycle after the event that caused it. A corrupted active-register select or a lost pending mark is subtler. It shows up as a duty that is off by the difference between the two compare values. This appears only from the first wrap after the fault, so it can take up to one full period to surface. The bench compares every cycle against a model and also measures duty over whole periods, which catches both kinds of fault.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP0   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP1   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CFG0   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CFG1   = 3'd5;
    localparam int unsigned FLAG_CLR_BIT = 7;
    localparam int unsigned NUM_CH = 2;

    typedef struct packed {
        logic       max_duty;
        logic       tog_ovf;
        logic [1:0] lvl_sel;
        logic [1:0] mode;
    } chan_cfg_t;

    typedef enum logic [1:0] {MODE_OFF, MODE_DIRECT, MODE_BUFFERED} out_mode_e;

    function automatic out_mode_e decode_mode(logic [1:0] m);
        if (m[1]) return MODE_BUFFERED;
        if (m[0]) return MODE_DIRECT;
        return MODE_OFF;
    endfunction
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = run_i && (cnt_q.cnt == period_i);
        if (run_i) cnt_d.cnt = wrap_o ? '0 : cnt_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q.cnt;

    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> cnt_o == '0);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wrap_o) |=> cnt_o == $past(cnt_o) + 1'b1);
    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(cnt_o));
endmodule

// File: rtl/pwmt_cmp_bank.sv
module pwmt_cmp_bank
    import pwmt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              buffered_i,
    input  logic              wrap_i,
    input  logic [W-1:0]      cnt_i,
    input  logic [NUM_CH-1:0] wr_cmp_i,
    input  logic [W-1:0]      wr_data_i,
    input  logic [NUM_CH-1:0] clr_flag_i,
    output logic [W-1:0]      act_cmp_o,
    output logic [NUM_CH-1:0] flag_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][W-1:0] cmp;
        logic [NUM_CH-1:0]        flag;
        logic [NUM_CH-1:0]        pend;
        logic                     sel;
        logic [W-1:0]             act;
    } bank_st_t;

    bank_st_t bank_d, bank_q;
    logic [NUM_CH-1:0] hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c] = run_i && (cnt_i == bank_q.cmp[c]);

        p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[c] |=> flag_o[c]);
    end

    always_comb begin
        bank_d = bank_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_cmp_i[c]) bank_d.cmp[c] = wr_data_i;
            if (hit[c])             bank_d.flag[c] = 1'b1;
            else if (clr_flag_i[c]) bank_d.flag[c] = 1'b0;
        end
        if (buffered_i) begin
            if (wrap_i) begin
                if (bank_q.pend[~bank_q.sel]) begin
                    bank_d.sel                = ~bank_q.sel;
                    bank_d.act                = bank_q.cmp[~bank_q.sel];
                    bank_d.pend[~bank_q.sel]  = 1'b0;
                end else begin
                    bank_d.act = bank_q.cmp[bank_q.sel];
                end
            end
            for (int c = 0; c < NUM_CH; c++)
                if (wr_cmp_i[c] && (1'(c) != bank_d.sel)) bank_d.pend[c] = 1'b1;
        end else begin
            bank_d.sel  = 1'b0;
            bank_d.pend = '0;
            bank_d.act  = bank_q.cmp[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign act_cmp_o = buffered_i ? bank_q.act : bank_q.cmp[0];
    assign flag_o    = bank_q.flag;

    p_no_pend_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_q.pend[bank_q.sel]);
    p_act_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered_i && !wrap_i) |=> $stable(bank_q.act));
    p_switch_on_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered_i && wrap_i && bank_q.pend[~bank_q.sel]) |=> bank_q.sel != $past(bank_q.sel));
endmodule

// File: rtl/pwmt_out_stage.sv
module pwmt_out_stage
    import pwmt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  out_mode_e    mode_i,
    input  chan_cfg_t    cfg_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         wrap_i,
    output logic         pwm_o
);
    typedef struct packed {
        logic pwm;
    } out_st_t;

    out_st_t out_d, out_q;
    logic    match, pulse_lvl, active, full;

    always_comb begin
        out_d     = out_q;
        match     = run_i && (cnt_i == cmp_i);
        pulse_lvl = ~cfg_i.lvl_sel[0];
        active    = run_i && (mode_i != MODE_OFF);
        full      = cfg_i.max_duty && cfg_i.tog_ovf;
        if (active) begin
            if (full)                              out_d.pwm = pulse_lvl;
            else if (match && cfg_i.lvl_sel[1])    out_d.pwm = cfg_i.lvl_sel[0];
            else if (wrap_i && cfg_i.tog_ovf)      out_d.pwm = ~out_q.pwm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pwm_o = out_q.pwm;

    p_full_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && full) |=> pwm_o == ~$past(cfg_i.lvl_sel[0]));
    p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.tog_ovf && cfg_i.lvl_sel == 2'b10 && !pwm_o) |=> !pwm_o);
    p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> $stable(pwm_o));
    p_cmp_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !full && match && wrap_i && cfg_i.lvl_sel[1]) |=> pwm_o == $past(cfg_i.lvl_sel[0]));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic              pwm_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              wrap_o,
    output logic              flag0_o,
    output logic              flag1_o
);
    localparam int unsigned CFG_W = $bits(chan_cfg_t);

    typedef struct packed {
        logic             halt;
        logic [CNT_W-1:0] period;
        chan_cfg_t        cfg0;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_CH-1:0] wr_cmp, clr_flag, flags;
    logic [CNT_W-1:0]  act_cmp;
    logic              run, wrap;
    out_mode_e         mode;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL:   regs_d.halt   = wr_data_i[0];
                A_PERIOD: regs_d.period = wr_data_i;
                A_CFG0:   regs_d.cfg0   = chan_cfg_t'(wr_data_i[CFG_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.halt   <= 1'b1;
            regs_q.period <= '1;
            regs_q.cfg0   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run         = !regs_q.halt;
    assign mode        = decode_mode(regs_q.cfg0.mode);
    assign wr_cmp[0]   = wr_en_i && (wr_addr_i == A_CMP0);
    assign wr_cmp[1]   = wr_en_i && (wr_addr_i == A_CMP1);
    assign clr_flag[0] = wr_en_i && (wr_addr_i == A_CFG0) && wr_data_i[FLAG_CLR_BIT];
    assign clr_flag[1] = wr_en_i && (wr_addr_i == A_CFG1) && wr_data_i[FLAG_CLR_BIT];

    pwmt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .period_i(regs_q.period),
        .cnt_o(count_o), .wrap_o(wrap)
    );

    pwmt_cmp_bank #(.W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .run_i(run), .buffered_i(mode == MODE_BUFFERED),
        .wrap_i(wrap), .cnt_i(count_o), .wr_cmp_i(wr_cmp), .wr_data_i(wr_data_i),
        .clr_flag_i(clr_flag), .act_cmp_o(act_cmp), .flag_o(flags)
    );

    pwmt_out_stage #(.W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode), .cfg_i(regs_q.cfg0),
        .cnt_i(count_o), .cmp_i(act_cmp), .wrap_i(wrap), .pwm_o(pwm_o)
    );

    assign wrap_o  = wrap;
    assign flag0_o = flags[0];
    assign flag1_o = flags[1];

    p_no_wrap_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.halt |-> !wrap_o);
endmodule

// File: tb/pwm_pair_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_pair_timer_tb_top;
    import pwmt_pkg::*;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_o, wrap_o, flag0_o, flag1_o;
    logic [W-1:0] count_o;

    always #2 clk = ~clk;

    pwm_pair_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pwm_o(pwm_o), .count_o(count_o), .wrap_o(wrap_o), .flag0_o(flag0_o), .flag1_o(flag1_o)
    );

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pwm;
        logic         wrap;
        logic         f0;
        logic         f1;
    } obs_t;

    obs_t  exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    string req = "R1";
    bit    done = 1'b0;

    // reference state built from the requirements
    logic         m_halt, m_pwm, m_f0, m_f1, m_sel;
    logic [W-1:0] m_per, m_cnt, m_c0, m_c1, m_act;
    logic [5:0]   m_cfg;
    logic [1:0]   m_pend;
    logic         t_run, t_wrap, t_buf, t_on, t_mt, t_sel;
    logic         n_pwm, n_f0, n_f1;
    logic [W-1:0] t_cmp, n_cnt, n_act;
    logic [1:0]   n_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_halt = 1'b1; m_per = '1; m_cnt = '0; m_c0 = '0; m_c1 = '0; m_cfg = '0;
            m_pwm = 1'b0; m_f0 = 1'b0; m_f1 = 1'b0; m_sel = 1'b0; m_act = '0; m_pend = '0;
        end else begin
            t_run  = !m_halt;
            t_wrap = t_run && (m_cnt == m_per);
            t_buf  = m_cfg[1];                                   // R4 priority
            t_on   = m_cfg[1] || m_cfg[0];
            t_cmp  = t_buf ? m_act : m_c0;
            t_mt   = t_run && (m_cnt == t_cmp);
            n_pwm  = m_pwm;
            if (t_run && t_on) begin
                if (m_cfg[5] && m_cfg[4])  n_pwm = ~m_cfg[2];    // R7
                else if (t_mt && m_cfg[3]) n_pwm = m_cfg[2];     // R5, R11
                else if (t_wrap && m_cfg[4]) n_pwm = ~m_pwm;     // R6
            end
            n_f0 = (t_run && m_cnt == m_c0) ? 1'b1 :
                   (wr_en && wr_addr == A_CFG0 && wr_data[7]) ? 1'b0 : m_f0;
            n_f1 = (t_run && m_cnt == m_c1) ? 1'b1 :
                   (wr_en && wr_addr == A_CFG1 && wr_data[7]) ? 1'b0 : m_f1;
            if (t_buf) begin                                      // R9
                t_sel = m_sel; n_act = m_act; n_pend = m_pend;
                if (t_wrap) begin
                    if (m_pend[~m_sel]) begin
                        t_sel = ~m_sel;
                        n_act = m_sel ? m_c0 : m_c1;
                        n_pend[~m_sel] = 1'b0;
                    end else begin
                        n_act = m_sel ? m_c1 : m_c0;
                    end
                end
                if (wr_en && wr_addr == A_CMP0 && t_sel != 1'b0) n_pend[0] = 1'b1;
                if (wr_en && wr_addr == A_CMP1 && t_sel != 1'b1) n_pend[1] = 1'b1;
            end else begin
                t_sel = 1'b0; n_pend = '0; n_act = m_c0;
            end
            n_cnt = t_run ? (t_wrap ? '0 : m_cnt + 1'b1) : m_cnt;
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL:   m_halt = wr_data[0];
                    A_PERIOD: m_per  = wr_data;
                    A_CMP0:   m_c0   = wr_data;
                    A_CMP1:   m_c1   = wr_data;
                    A_CFG0:   m_cfg  = wr_data[5:0];
                    default:  ;
                endcase
            end
            m_cnt = n_cnt; m_pwm = n_pwm; m_f0 = n_f0; m_f1 = n_f1;
            m_sel = t_sel; m_act = n_act; m_pend = n_pend;
        end
        exp_q.push_back({m_cnt, m_pwm, (!m_halt && m_cnt == m_per), m_f0, m_f1});
    end

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (!done && exp_q.size() > 0) begin
            obs_t e, a;
            e = exp_q.pop_front();
            a = {count_o, pwm_o, wrap_o, flag0_o, flag1_o};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s scoreboard: actual %h expected %h", req, a, e);
            end
        end
    end

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // counts high cycles over one period of 10 starting at count 0
    task automatic duty(string r, int exp_hi);
        int hi = 0;
        while (count_o != 0) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            if (pwm_o) hi++;
            @(negedge clk);
        end
        check(r, hi, exp_hi);
    endtask

    initial begin
        logic [W-1:0] held;
        logic         hp;
        idle(3);
        check("R1", {count_o, pwm_o, wrap_o, flag0_o, flag1_o}, '0);
        rst_n = 1'b1;
        idle(3);
        check("R1", count_o, 0);                                // halted after reset

        req = "R2";
        wr(A_PERIOD, 16'd9); wr(A_CTRL, 16'd0); idle(5);
        while (count_o != 9) @(negedge clk);
        check("R2", wrap_o, 1);
        @(negedge clk);
        check("R2", count_o, 0);
        idle(12);

        req = "R3";
        wr(A_CTRL, 16'd1); idle(2);
        held = count_o; idle(6);
        check("R3", count_o, held);
        check("R3", wrap_o, 0);
        wr(A_CTRL, 16'd0); idle(4);

        req = "R5";
        wr(A_CMP0, 16'd3); wr(A_CFG0, 16'h19); idle(25);
        duty("R5", 4);
        wr(A_CFG0, 16'h1D); idle(20);
        duty("R5", 6);

        req = "R8";
        wr(A_CFG0, 16'h19); wr(A_CMP0, 16'd6); idle(20);
        duty("R8", 7);

        req = "R6";
        wr(A_CFG0, 16'h09); idle(20);
        duty("R6", 0);

        req = "R7";
        wr(A_CFG0, 16'h39); idle(5);
        duty("R7", 10);

        req = "R9";
        wr(A_CFG0, 16'h19); wr(A_CMP0, 16'd2); wr(A_CFG0, 16'h1A); idle(20);
        duty("R9", 3);
        wr(A_CMP1, 16'd7); idle(25);
        duty("R9", 8);
        wr(A_CMP1, 16'd5); idle(25);
        duty("R9", 6);
        wr(A_CMP0, 16'd1); idle(25);
        duty("R9", 2);

        req = "R4";
        wr(A_CFG0, 16'h1B); idle(25);
        duty("R4", 2);
        wr(A_CFG0, 16'h18); idle(2);
        hp = pwm_o; idle(25);
        check("R4", pwm_o, hp);

        req = "R10";
        wr(A_CTRL, 16'd1);
        wr(A_CFG0, 16'h98); wr(A_CFG1, 16'h80); idle(2);
        check("R10", flag0_o, 0);
        check("R10", flag1_o, 0);
        wr(A_CTRL, 16'd0); idle(12);
        check("R10", flag0_o, 1);
        check("R10", flag1_o, 1);

        req = "R11";
        wr(A_CFG0, 16'h19); wr(A_CMP0, 16'd9); idle(25);
        duty("R11", 0);

        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule